// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block makes the receive-side accept/reject decision for an Ethernet frame using only the frame's 48-bit destination address. A start-of-frame strobe opens a frame. The six destination bytes then arrive one at a time on a byte strobe, and gaps of any length between bytes are allowed. The block compares them on the fly against a programmed station address. It also notes whether the first byte marks a group (multicast) address.

An external CRC unit supplies a running CRC-32. The top six bits of that value index a 64-bit multicast hash table, which is held as a high and a low 32-bit word. Four filter modes pick how the exact-match result and the hash bit combine. Two overrides sit above all modes: one passes every multicast frame, and one passes every frame.

The verdict comes out once per frame, registered, one cycle after the sixth destination byte. Bytes after the sixth are ignored until the next start-of-frame.

Top module: `ether_da_filter`

## Requirements
- R1: `verdictVld` pulses high for exactly one cycle, one clock after the cycle in which the sixth destination byte is taken. It does not pulse again before the next `sofStb`, whatever bytes follow.
- R2: With `filtMode` = 0 (exact), `accept` is 1 only when all six bytes equal `stationAddr`. Byte k on the wire (k = 0 first) is compared with `stationAddr[8k+7:8k]`.
- R3: With `filtMode` = 1 (hash only), `accept` equals the hash-table bit selected by `crcIn[31:26]`, for unicast and multicast frames alike.
- R4: With `filtMode` = 2 (hash plus exact), a unicast destination (bit 0 of byte 0 clear) is accepted only on an exact match with `stationAddr`.
- R5: With `filtMode` = 2, a multicast destination (bit 0 of byte 0 set, broadcast included) is accepted when its hash bit is set. If `crcIn[31]` is 1, the bit is `hashHi[crcIn[30:26]]`; otherwise it is `hashLo[crcIn[30:26]]`. So index 63 selects `hashHi[31]`. `crcIn` is sampled in the cycle the sixth byte is taken.
- R6: With `filtMode` = 3 (inverse), `accept` is 1 when the destination differs from `stationAddr` and 0 when it matches.
- R7: When `passAllMcast` is 1, every multicast destination is accepted in every mode.
- R8: When `promisc` is 1, every frame is accepted whatever its destination, broadcast included.
- R9: `sofStb` discards any partly received address, so the next six bytes form a fresh destination address.
- R10: While `rstN` is low, and after reset until the first verdict, `verdictVld` and `accept` are 0.
- R11: Idle cycles between destination bytes (`byteVld` low) do not change the verdict or its timing relative to the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sofStb | input | 1 | Start of a new frame; clears per-frame state |
| byteVld | input | 1 | `byteData` carries a destination byte this cycle |
| byteData | input | 8 | Destination address byte, first wire byte first |
| crcIn | input | 32 | Running CRC-32 over the destination bytes from an external unit |
| stationAddr | input | 48 | Programmed station address, wire byte k in bits [8k+7:8k] |
| hashHi | input | 32 | Upper 32 bits of the multicast hash table |
| hashLo | input | 32 | Lower 32 bits of the multicast hash table |
| filtMode | input | 2 | 0 exact, 1 hash only, 2 hash plus exact, 3 inverse |
| passAllMcast | input | 1 | Accept all multicast frames |
| promisc | input | 1 | Accept all frames |
| accept | output | 1 | Verdict, meaningful while `verdictVld` is high |
| verdictVld | output | 1 | One-cycle verdict strobe |

## Verification
Only one result is timed: the verdict. It becomes visible in the cycle after the clock edge that takes the sixth destination byte. The bench drives inputs on falling edges. It reads `verdictVld` and `accept` at the falling edge right after the sixth byte's rising edge, and again one cycle later to confirm the strobe has dropped. Frames sent with gaps, frames aborted by a new start-of-frame, and bytes sent after the address are checked cycle by cycle. Any stray strobe is caught in the cycle it would appear.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int DA_BYTES = 6;
  localparam int IDX_W    = $clog2(DA_BYTES);
  localparam int CRC_W    = 32;
  localparam int HASH_W   = 6;

  typedef enum logic [1:0] {
    FILT_EXACT      = 2'd0,
    FILT_HASH       = 2'd1,
    FILT_HASH_EXACT = 2'd2,
    FILT_INVERSE    = 2'd3
  } filtMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             clear;  // new frame: drop running state
    logic             take;   // consume byteData this cycle
    logic [IDX_W-1:0] idx;    // position of the byte being taken
    logic             last;   // this is the final address byte
  } ctrlStb_t;
endpackage

// File: rtl/dafilt_ctrl.sv
module dafilt_ctrl
  import dafilt_pkg::*;
#(
  parameter int NUM_BYTES = DA_BYTES
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sofStb,
  input  logic     byteVld,
  output ctrlStb_t stb
);
  localparam int CW = $clog2(NUM_BYTES + 1);

  logic [CW-1:0] byteCnt;
  logic [CW-1:0] baseCnt;

  // a byte arriving with sofStb counts as the first byte of the new frame
  assign baseCnt   = sofStb ? '0 : byteCnt;
  assign stb.clear = sofStb;
  assign stb.take  = byteVld && (baseCnt < CW'(NUM_BYTES));
  assign stb.idx   = IDX_W'(baseCnt);
  assign stb.last  = stb.take && (baseCnt == CW'(NUM_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      byteCnt <= '0;
    else if (stb.take)
      byteCnt <= baseCnt + CW'(1);
    else if (sofStb)
      byteCnt <= '0;
  end
endmodule

// File: rtl/dafilt_datapath.sv
module dafilt_datapath
  import dafilt_pkg::*;
#(
  parameter int NUM_BYTES = DA_BYTES,
  parameter int CRC_BITS  = CRC_W,
  parameter int HASH_BITS = HASH_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStb_t               stb,
  input  logic [7:0]             byteData,
  input  logic [CRC_BITS-1:0]    crcIn,
  input  logic [8*NUM_BYTES-1:0] stationAddr,
  input  logic [31:0]            hashHi,
  input  logic [31:0]            hashLo,
  input  logic [1:0]             filtMode,
  input  logic                   passAllMcast,
  input  logic                   promisc,
  output logic                   accept,
  output logic                   verdictVld,
  output logic                   matchFlag,
  output logic                   mcastFlag
);
  localparam int SLOTS = 2 ** IDX_W;

  logic [7:0] staByte [SLOTS];
  logic [7:0] staSel;

  // station address split into wire-order bytes, spare slots tied low
  for (genvar g = 0; g < SLOTS; g++) begin : g_sta
    if (g < NUM_BYTES) begin : g_used
      assign staByte[g] = stationAddr[8*g +: 8];
    end else begin : g_pad
      assign staByte[g] = 8'h00;
    end
  end
  assign staSel = staByte[stb.idx];

  // running exact-match and group-address state
  logic matchPrev, matchNext, mcastPrev, mcastNext;
  assign matchPrev = stb.clear ? 1'b1 : matchFlag;
  assign mcastPrev = stb.clear ? 1'b0 : mcastFlag;
  assign matchNext = stb.take ? (matchPrev && (byteData == staSel)) : matchPrev;
  assign mcastNext = (stb.take && (stb.idx == '0)) ? byteData[0] : mcastPrev;

  // hash lookup from the top bits of the running CRC
  logic [HASH_BITS-1:0] hashIdx;
  logic [63:0]          hashTable;
  logic                 hashBit;
  logic                 unusedCrcLow;
  assign hashIdx      = crcIn[CRC_BITS-1 -: HASH_BITS];
  assign hashTable    = {hashHi, hashLo};
  assign hashBit      = hashTable[hashIdx];
  assign unusedCrcLow = ^crcIn[CRC_BITS-HASH_BITS-1:0];

  filtMode_e modeSel;
  logic      modeAccept, decision;
  assign modeSel = filtMode_e'(filtMode);

  always_comb begin
    unique case (modeSel)
      FILT_EXACT:      modeAccept = matchNext;
      FILT_HASH:       modeAccept = hashBit;
      FILT_HASH_EXACT: modeAccept = mcastNext ? hashBit : matchNext;
      FILT_INVERSE:    modeAccept = !matchNext;
      default:         modeAccept = 1'b0;
    endcase
  end

  assign decision = promisc || (passAllMcast && mcastNext) || modeAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag  <= 1'b1;
      mcastFlag  <= 1'b0;
      accept     <= 1'b0;
      verdictVld <= 1'b0;
    end else begin
      matchFlag  <= matchNext;
      mcastFlag  <= mcastNext;
      verdictVld <= stb.last;
      if (stb.last)
        accept <= decision;
    end
  end
endmodule

// File: rtl/ether_da_filter.sv
module ether_da_filter
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sofStb,
  input  logic        byteVld,
  input  logic [7:0]  byteData,
  input  logic [31:0] crcIn,
  input  logic [47:0] stationAddr,
  input  logic [31:0] hashHi,
  input  logic [31:0] hashLo,
  input  logic [1:0]  filtMode,
  input  logic        passAllMcast,
  input  logic        promisc,
  output logic        accept,
  output logic        verdictVld
);
  ctrlStb_t stb;
  logic     matchFlag;
  logic     mcastFlag;

  dafilt_ctrl #(.NUM_BYTES(DA_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sofStb  (sofStb),
    .byteVld (byteVld),
    .stb     (stb)
  );

  dafilt_datapath #(
    .NUM_BYTES (DA_BYTES),
    .CRC_BITS  (CRC_W),
    .HASH_BITS (HASH_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .byteData     (byteData),
    .crcIn        (crcIn),
    .stationAddr  (stationAddr),
    .hashHi       (hashHi),
    .hashLo       (hashLo),
    .filtMode     (filtMode),
    .passAllMcast (passAllMcast),
    .promisc      (promisc),
    .accept       (accept),
    .verdictVld   (verdictVld),
    .matchFlag    (matchFlag),
    .mcastFlag    (mcastFlag)
  );
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       byteVld,
  input logic [1:0] filtMode,
  input logic       passAllMcast,
  input logic       promisc,
  input logic       accept,
  input logic       verdictVld,
  input logic       matchFlag,
  input logic       mcastFlag
);
  // R1
  verdict_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictVld |-> $past(byteVld));

  // R1
  verdict_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictVld |=> !verdictVld);

  // R2
  exact_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictVld && $past(filtMode) == 2'd0 && !$past(promisc) && !($past(passAllMcast) && mcastFlag))
      |-> (accept == matchFlag));

  // R6
  inverse_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictVld && $past(filtMode) == 2'd3 && !$past(promisc) && !($past(passAllMcast) && mcastFlag))
      |-> (accept == !matchFlag));

  // R7
  pass_mcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictVld && $past(passAllMcast) && mcastFlag) |-> accept);

  // R8
  promisc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictVld && $past(promisc)) |-> accept);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!verdictVld && !accept));
endmodule

bind ether_da_filter dafilt_chk u_dafilt_chk (
  .clk          (clk),
  .rstN         (rstN),
  .byteVld      (byteVld),
  .filtMode     (filtMode),
  .passAllMcast (passAllMcast),
  .promisc      (promisc),
  .accept       (accept),
  .verdictVld   (verdictVld),
  .matchFlag    (matchFlag),
  .mcastFlag    (mcastFlag)
);

// File: tb/test_ether_da_filter.sv
module test_ether_da_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sofStb = 1'b0;
  logic        byteVld = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic [31:0] crcIn = 32'h0;
  logic [47:0] stationAddr = 48'h5544_3322_1100;
  logic [31:0] hashHi = 32'h8000_0001;
  logic [31:0] hashLo = 32'h8000_0000;
  logic [1:0]  filtMode = 2'd0;
  logic        passAllMcast = 1'b0;
  logic        promisc = 1'b0;
  logic        accept;
  logic        verdictVld;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ether_da_filter i_ether_da_filter (
    .clk(clk), .rstN(rstN), .sofStb(sofStb), .byteVld(byteVld),
    .byteData(byteData), .crcIn(crcIn), .stationAddr(stationAddr),
    .hashHi(hashHi), .hashLo(hashLo), .filtMode(filtMode),
    .passAllMcast(passAllMcast), .promisc(promisc),
    .accept(accept), .verdictVld(verdictVld)
  );

  localparam logic [47:0] UNI_OTHER = 48'h5545_3322_1100;  // byte 4 differs
  localparam logic [47:0] MCAST_DA  = 48'h0100_5E00_0001;  // byte0 = 01
  localparam logic [47:0] BCAST_DA  = 48'hFFFF_FFFF_FFFF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected verdict computed from the requirements
  function automatic logic model(input logic [47:0] da, input logic [31:0] crc);
    logic [63:0] tbl;
    logic        match, mc, hb, base;
    tbl   = {hashHi, hashLo};
    match = (da == stationAddr);
    mc    = da[0];
    hb    = tbl[crc[31:26]];
    case (filtMode)
      2'd0:    base = match;
      2'd1:    base = hb;
      2'd2:    base = mc ? hb : match;
      default: base = !match;
    endcase
    return promisc || (passAllMcast && mc) || base;
  endfunction

  task automatic sendByte(input logic [7:0] b);
    byteVld  = 1'b1;
    byteData = b;
    @(negedge clk);
    byteVld  = 1'b0;
  endtask

  // start a frame and send six address bytes; returns at the verdict cycle
  task automatic sendFrame(input logic [47:0] da, input logic [31:0] crc, input int gap,
                           input string req);
    @(negedge clk);
    sofStb = 1'b1;
    crcIn  = crc;
    @(negedge clk);
    sofStb = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sendByte(da[8*i +: 8]);
      if (i < 5) begin
        for (int j = 0; j < gap; j++) begin
          chk({req, " no early verdict"}, {31'd0, verdictVld}, 32'd0);
          @(negedge clk);
        end
      end
    end
  endtask

  task automatic frameCheck(input string req, input logic [47:0] da, input logic [31:0] crc,
                            input int gap);
    logic exp;
    exp = model(da, crc);
    sendFrame(da, crc, gap, req);
    chk({req, " verdict strobe"}, {31'd0, verdictVld}, 32'd1);
    chk({req, " verdict"}, {31'd0, accept}, {31'd0, exp});
    @(negedge clk);
    chk({req, " strobe drops"}, {31'd0, verdictVld}, 32'd0);
  endtask

  task automatic testReset();
    chk("R10 vld in reset", {31'd0, verdictVld}, 32'd0);
    chk("R10 accept in reset", {31'd0, accept}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 vld after reset", {31'd0, verdictVld}, 32'd0);
  endtask

  task automatic testExact();
    filtMode = 2'd0;
    frameCheck("R2 exact match", stationAddr, 32'h0, 0);
    frameCheck("R2 exact mismatch", UNI_OTHER, 32'hFC00_0000, 0);
    frameCheck("R2 multicast no match", MCAST_DA, 32'hFC00_0000, 0);
  endtask

  task automatic testHashOnly();
    filtMode = 2'd1;
    frameCheck("R3 unicast hash hit", UNI_OTHER, 32'h8000_0000, 0);
    frameCheck("R3 station hash miss", stationAddr, 32'h0400_0000, 0);
  endtask

  task automatic testHashExact();
    filtMode = 2'd2;
    frameCheck("R4 unicast match", stationAddr, 32'h0000_0000, 0);
    frameCheck("R4 unicast mismatch hash set", UNI_OTHER, 32'hFC00_0000, 0);
    frameCheck("R5 idx63 hashHi bit31", MCAST_DA, 32'hFC00_0000, 0);
    frameCheck("R5 idx31 hashLo bit31", MCAST_DA, 32'h7C00_0000, 0);
    frameCheck("R5 idx32 hashHi bit0", MCAST_DA, 32'h8000_0000, 0);
    frameCheck("R5 idx0 miss", MCAST_DA, 32'h0000_0000, 0);
    frameCheck("R5 broadcast miss", BCAST_DA, 32'h0400_0000, 0);
  endtask

  task automatic testInverse();
    filtMode = 2'd3;
    frameCheck("R6 match rejected", stationAddr, 32'hFC00_0000, 0);
    frameCheck("R6 mismatch accepted", UNI_OTHER, 32'h0, 0);
  endtask

  task automatic testPassMcast();
    passAllMcast = 1'b1;
    filtMode = 2'd0;
    frameCheck("R7 exact mode multicast", MCAST_DA, 32'h0, 0);
    filtMode = 2'd3;
    frameCheck("R7 inverse mode multicast", MCAST_DA, 32'h0, 0);
    frameCheck("R7 unicast unaffected", stationAddr, 32'h0, 0);
    passAllMcast = 1'b0;
  endtask

  task automatic testPromisc();
    promisc = 1'b1;
    filtMode = 2'd0;
    frameCheck("R8 broadcast", BCAST_DA, 32'h0, 0);
    filtMode = 2'd3;
    frameCheck("R8 inverse station", stationAddr, 32'h0, 0);
    promisc = 1'b0;
  endtask

  task automatic testGaps();
    filtMode = 2'd2;
    frameCheck("R11 gapped unicast", stationAddr, 32'h0, 3);
    frameCheck("R11 gapped multicast", MCAST_DA, 32'h0400_0000, 2);
  endtask

  task automatic testExtraBytes();
    filtMode = 2'd0;
    frameCheck("R1 exact then trailer", stationAddr, 32'h0, 0);
    for (int i = 0; i < 8; i++) begin
      sendByte(8'hA0 + 8'(i));
      chk("R1 no second verdict", {31'd0, verdictVld}, 32'd0);
    end
  endtask

  task automatic testSofAbort();
    filtMode = 2'd0;
    @(negedge clk);
    sofStb = 1'b1;
    @(negedge clk);
    sofStb = 1'b0;
    // partial mismatching address, then restart with the station address
    for (int i = 0; i < 4; i++) begin
      sendByte(8'hEE);
      chk("R9 partial no verdict", {31'd0, verdictVld}, 32'd0);
    end
    frameCheck("R9 restart matches", stationAddr, 32'h0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    testReset();
    testExact();
    testHashOnly();
    testHashExact();
    testInverse();
    testPassMcast();
    testPromisc();
    testGaps();
    testExtraBytes();
    testSofAbort();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule